// File: doc/BRIEF.md
# SPI Serial Clock Generator

This block turns a system clock into the serial clock of an SPI controller and tells the neighbouring shift engine when to act. The engine raises a bit request; the generator then runs one serial-clock period. That period has a leading phase, in which SCLK sits opposite its rest level, and a trailing phase, in which SCLK has returned to rest. In the same cycles as the SCLK edges it pulses a launch strobe, which tells the engine to drive its next output bit, and a sample strobe, which tells it to capture the input line. Polarity sets the rest level of SCLK. Phase sets which edge launches and which edge samples. A late-capture option moves sampling half a period later. This gives timing margin at the fastest divide ratios, where the input returns late relative to the edge.

A 5-bit prescale field sets the period length in system cycles. It has two ranges. Small values select the divisor directly. Values from 16 upward select even divisors in steps of two, up to 30. Values that would give a divisor below 2 run at the fastest rate, in which each phase lasts one system cycle.

The control is a three-state machine. In IDLE, SCLK rests at the polarity level. The START transition (IDLE to LEAD) happens when enable and a bit request are both present. It captures the prescale and mode inputs for the bit. LEAD runs for the leading half, and the HALF transition takes it to TRAIL. At the end of TRAIL there are two transitions. CHAIN goes straight back to LEAD if enable and the request are still high. STOP returns to IDLE otherwise.

Top module: `spi_sclk_gen`

## Requirements
Cycle index 0 is the first cycle after the clock edge at which an idle generator sees enable and bit request both high. A bit's period P is the number of cycles from index 0 until idle_o rises again. The leading phase lasts ceil(P/2) cycles and the trailing phase lasts floor(P/2) cycles.

- R1: For prescale field values 2 to 15, P equals the field value.
- R2: Field values 0, 1 and 16 give P = 2, with one cycle in each phase.
- R3: Field values 17 to 31 give P = 2 × (field − 16), so the longest period is 30 cycles.
- R4: While idle, sclk_o equals cpol_i as it was one cycle earlier. During the leading phase sclk_o is the inverse of the polarity captured at START.
- R5: With cpha_i = 0 and late capture off, sample_o pulses at index 0 and launch_o pulses at index ceil(P/2). Each pulses exactly once per bit.
- R6: With cpha_i = 1 and late capture off, launch_o pulses at index 0 and sample_o pulses at index ceil(P/2). Each pulses exactly once per bit.
- R7: With late_capture_i = 1, the sample pulse moves half a period later. It comes at index ceil(P/2) when cpha_i = 0 and at index P when cpha_i = 1. The launch pulse does not move.
- R8: A change of the prescale field while a bit is in progress does not alter that bit's period. The new value applies at the next START from IDLE.
- R9: With enable_i low, a bit request does not leave IDLE and no strobe pulses. Dropping enable_i during a bit does not shorten that bit.
- R10: If enable_i and bit_req_i are high in the last trailing cycle, the next bit's leading phase follows with no idle cycle between the two bits.
- R11: During reset, idle_o = 1, launch_o = 0, sample_o = 0 and sclk_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Permits new bits to start |
| presc_field_i | input | 5 | Prescale field: direct divisor or offset even divisor |
| cpol_i | input | 1 | SCLK rest level |
| cpha_i | input | 1 | 0: sample on first edge; 1: launch on first edge |
| late_capture_i | input | 1 | Delays the sample strobe by half a period |
| bit_req_i | input | 1 | Shift engine asks for one serial bit period |
| sclk_o | output | 1 | Serial clock |
| launch_o | output | 1 | One-cycle pulse: drive the next output bit |
| sample_o | output | 1 | One-cycle pulse: capture the input bit |
| idle_o | output | 1 | No bit in progress |

## Verification
Two situations are hard to reach from the ports: the CHAIN transition, and a configuration change that lands inside a running bit. To reach CHAIN, the bench holds bit_req_i high through the final trailing cycle and releases it only after the second bit has started. It then checks that idle_o never rises between the bits and that two launch and two sample pulses appear. For a mid-bit change, the bench alters the prescale field, or drops enable_i, in index 1 of a long bit. It then measures the full period at the ports and runs a fresh bit to show that the new field takes effect only after IDLE.

// File: rtl/spi_sclk_gen_pkg.sv
package spi_sclk_gen_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LEAD  = 2'd1,
        PH_TRAIL = 2'd2
    } phase_t;

    typedef struct packed {
        logic cpol;
        logic cpha;
        logic late;
    } mode_t;

endpackage

// File: rtl/spi_div_decode.sv
module spi_div_decode #(
    parameter int FIELD_W    = 5,
    parameter int DIRECT_MAX = 15,
    parameter int HALF_W     = FIELD_W
) (
    input  logic [FIELD_W-1:0] field_i,
    output logic [HALF_W-1:0]  lead_len_o,
    output logic [HALF_W-1:0]  trail_len_o
);
    localparam int DIV_W     = FIELD_W + 1;
    localparam int FIELD_MAX = (1 << FIELD_W) - 1;
    localparam int EVEN_BASE = DIRECT_MAX + 1;

    logic [DIV_W-1:0] div_n;

    generate
        if (FIELD_MAX > DIRECT_MAX) begin : g_two_range
            // upper codes select even divisors counted from EVEN_BASE
            always_comb begin
                if (int'(field_i) <= DIRECT_MAX)
                    div_n = DIV_W'(field_i);
                else
                    div_n = DIV_W'((int'(field_i) - EVEN_BASE) * 2);
            end
        end else begin : g_direct_only
            always_comb div_n = DIV_W'(field_i);
        end
    endgenerate

    // divisors below two run at the fastest rate: one cycle per phase
    always_comb begin
        if (div_n < DIV_W'(2)) begin
            lead_len_o  = HALF_W'(1);
            trail_len_o = HALF_W'(1);
        end else begin
            lead_len_o  = HALF_W'((int'(div_n) + 1) / 2);
            trail_len_o = HALF_W'(int'(div_n) / 2);
        end
    end

endmodule

// File: rtl/spi_phase_timer.sv
module spi_phase_timer #(
    parameter int HALF_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [HALF_W-1:0] load_val_i,
    output logic              last_o
);
    logic [HALF_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - HALF_W'(1);
    end

    assign last_o = (cnt_q == '0);

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
    import spi_sclk_gen_pkg::*;
#(
    parameter int FIELD_W    = 5,
    parameter int DIRECT_MAX = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable_i,
    input  logic [FIELD_W-1:0] presc_field_i,
    input  logic               cpol_i,
    input  logic               cpha_i,
    input  logic               late_capture_i,
    input  logic               bit_req_i,
    output logic               sclk_o,
    output logic               launch_o,
    output logic               sample_o,
    output logic               idle_o
);
    localparam int HALF_W = FIELD_W;

    phase_t            state_q, state_d;
    mode_t             mode_q, mode_live, mode_eff;
    logic [HALF_W-1:0] lead_live, trail_live;
    logic [HALF_W-1:0] lead_q, trail_q;
    logic              tmr_load, tmr_last, cap_cfg, start_ok;
    logic [HALF_W-1:0] tmr_val;
    logic              enter_lead, enter_trail, leave_trail;
    logic              chk_armed_q;

    spi_div_decode #(
        .FIELD_W   (FIELD_W),
        .DIRECT_MAX(DIRECT_MAX),
        .HALF_W    (HALF_W)
    ) u_decode (
        .field_i    (presc_field_i),
        .lead_len_o (lead_live),
        .trail_len_o(trail_live)
    );

    spi_phase_timer #(
        .HALF_W(HALF_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .load_val_i(tmr_val),
        .last_o    (tmr_last)
    );

    assign start_ok  = enable_i && bit_req_i;
    assign mode_live = '{cpol: cpol_i, cpha: cpha_i, late: late_capture_i};
    assign mode_eff  = (state_q == PH_IDLE) ? mode_live : mode_q;

    // next state and timer control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = lead_live - HALF_W'(1);
        cap_cfg  = 1'b0;
        unique case (state_q)
            PH_IDLE: begin
                if (start_ok) begin          // START
                    state_d  = PH_LEAD;
                    tmr_load = 1'b1;
                    tmr_val  = lead_live - HALF_W'(1);
                    cap_cfg  = 1'b1;
                end
            end
            PH_LEAD: begin
                if (tmr_last) begin          // HALF
                    state_d  = PH_TRAIL;
                    tmr_load = 1'b1;
                    tmr_val  = trail_q - HALF_W'(1);
                end
            end
            PH_TRAIL: begin
                if (tmr_last) begin
                    if (start_ok) begin      // CHAIN
                        state_d  = PH_LEAD;
                        tmr_load = 1'b1;
                        tmr_val  = lead_q - HALF_W'(1);
                    end else begin           // STOP
                        state_d = PH_IDLE;
                    end
                end
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // state register and per-bit configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            mode_q  <= '0;
            lead_q  <= HALF_W'(1);
            trail_q <= HALF_W'(1);
        end else begin
            state_q <= state_d;
            if (cap_cfg) begin
                mode_q  <= mode_live;
                lead_q  <= lead_live;
                trail_q <= trail_live;
            end
        end
    end

    assign enter_lead  = (state_d == PH_LEAD)  && (state_q != PH_LEAD);
    assign enter_trail = (state_d == PH_TRAIL) && (state_q == PH_LEAD);
    assign leave_trail = (state_q == PH_TRAIL) && (state_d != PH_TRAIL);

    // registered outputs aligned with the SCLK edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_o   <= 1'b0;
            launch_o <= 1'b0;
            sample_o <= 1'b0;
        end else begin
            sclk_o   <= (state_d == PH_LEAD) ? ~mode_eff.cpol : mode_eff.cpol;
            launch_o <= mode_eff.cpha ? enter_lead : enter_trail;
            if (mode_eff.cpha)
                sample_o <= mode_eff.late ? leave_trail : enter_trail;
            else
                sample_o <= mode_eff.late ? enter_trail : enter_lead;
        end
    end

    assign idle_o = (state_q == PH_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chk_armed_q <= 1'b0;
        else        chk_armed_q <= 1'b1;
    end

    // R4
    sclk_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed_q && idle_o && $past(idle_o)) |-> (sclk_o == $past(cpol_i)));

    // R5
    launch_second_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_o && !mode_q.cpha) |-> (sclk_o == mode_q.cpol));

    // R6
    launch_first_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_o && mode_q.cpha) |-> (sclk_o != mode_q.cpol));

    // R7
    late_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed_q && sample_o && mode_q.cpha && mode_q.late) |-> ($past(state_q) == PH_TRAIL));

    // R9
    no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_o && !enable_i) |=> idle_o);

    // R10
    chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_TRAIL && tmr_last && start_ok) |=> (!idle_o && sclk_o != mode_q.cpol));

endmodule

// File: tb/spi_sclk_gen_bench.sv
`timescale 1ns/1ps
module spi_sclk_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b1;
    logic [4:0] field = 5'd2;
    logic       cpol = 1'b0;
    logic       cpha = 1'b0;
    logic       late = 1'b0;
    logic       bit_req = 1'b0;
    logic       sclk, launch, sample, idle;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    spi_sclk_gen u_spi_sclk_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable_i      (enable),
        .presc_field_i (field),
        .cpol_i        (cpol),
        .cpha_i        (cpha),
        .late_capture_i(late),
        .bit_req_i     (bit_req),
        .sclk_o        (sclk),
        .launch_o      (launch),
        .sample_o      (sample),
        .idle_o        (idle)
    );

    // {field, cpol, cpha, late, period}
    localparam logic [12:0] VEC [12] = '{
        {5'd0,  1'b0, 1'b0, 1'b0, 5'd2},
        {5'd1,  1'b1, 1'b1, 1'b0, 5'd2},
        {5'd2,  1'b0, 1'b1, 1'b1, 5'd2},
        {5'd3,  1'b1, 1'b0, 1'b0, 5'd3},
        {5'd7,  1'b0, 1'b0, 1'b1, 5'd7},
        {5'd15, 1'b1, 1'b1, 1'b1, 5'd15},
        {5'd16, 1'b0, 1'b0, 1'b0, 5'd2},
        {5'd17, 1'b1, 1'b0, 1'b1, 5'd2},
        {5'd18, 1'b0, 1'b1, 1'b0, 5'd4},
        {5'd24, 1'b1, 1'b1, 1'b0, 5'd16},
        {5'd25, 1'b0, 1'b1, 1'b1, 5'd18},
        {5'd31, 1'b0, 1'b0, 1'b0, 5'd30}
    };

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Runs one request from idle; index 0 is the first cycle after acceptance.
    task automatic measure(input int hold, input int chg_field, input bit drop_en,
                           output int busy, output int lead_n,
                           output int l_idx, output int l_n,
                           output int s_idx, output int s_n);
        @(negedge clk);
        bit_req = 1'b1;
        busy = -1; lead_n = 0; l_idx = -1; l_n = 0; s_idx = -1; s_n = 0;
        for (int idx = 0; idx < 100; idx++) begin
            @(negedge clk);
            if (launch) begin
                if (l_idx < 0) l_idx = idx;
                l_n++;
            end
            if (sample) begin
                if (s_idx < 0) s_idx = idx;
                s_n++;
            end
            if (idle) begin
                busy = idx;
                break;
            end
            if (sclk != cpol) lead_n++;
            if (idx >= hold) bit_req = 1'b0;
            if (idx == 1 && chg_field >= 0) field = 5'(chg_field);
            if (idx == 1 && drop_en) enable = 1'b0;
        end
        bit_req = 1'b0;
        enable = 1'b1;
    endtask

    initial begin
        #500000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int busy, lead_n, l_idx, l_n, s_idx, s_n;

        // R11: reset state, with polarity high to show sclk still held low
        cpol = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11", "idle in reset", int'(idle), 1);
        chk("R11", "launch in reset", int'(launch), 0);
        chk("R11", "sample in reset", int'(sample), 0);
        chk("R11", "sclk in reset", int'(sclk), 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R4", "idle sclk at cpol=1", int'(sclk), 1);
        cpol = 1'b0;
        @(negedge clk);
        chk("R4", "idle sclk at cpol=0", int'(sclk), 0);

        // table walk over both prescale ranges and all modes
        foreach (VEC[i]) begin
            int per, ld, exp_l, exp_s, f;
            string tg, tl, ts;
            f    = int'(VEC[i][12:8]);
            per  = int'(VEC[i][4:0]);
            ld   = (per + 1) / 2;
            @(negedge clk);
            field = VEC[i][12:8];
            cpol  = VEC[i][7];
            cpha  = VEC[i][6];
            late  = VEC[i][5];
            @(negedge clk);
            chk("R4", "rest level before bit", int'(sclk), int'(cpol));
            if (f >= 2 && f <= 15)      tg = "R1";
            else if (f <= 1 || f == 16) tg = "R2";
            else                        tg = "R3";
            tl = cpha ? "R6" : "R5";
            ts = late ? "R7" : (cpha ? "R6" : "R5");
            exp_l = cpha ? 0 : ld;
            if (cpha) exp_s = late ? per : ld;
            else      exp_s = late ? ld : 0;
            measure(0, -1, 1'b0, busy, lead_n, l_idx, l_n, s_idx, s_n);
            chk(tg, "period", busy, per);
            chk(tg, "leading cycles", lead_n, ld);
            chk(tl, "launch index", l_idx, exp_l);
            chk(tl, "launch count", l_n, 1);
            chk(ts, "sample index", s_idx, exp_s);
            chk(ts, "sample count", s_n, 1);
        end

        // R8: field changed mid-bit does not alter the running bit
        @(negedge clk);
        field = 5'd20; cpol = 1'b0; cpha = 1'b0; late = 1'b0;
        measure(0, 3, 1'b0, busy, lead_n, l_idx, l_n, s_idx, s_n);
        chk("R8", "period kept after mid-bit change", busy, 8);
        chk("R8", "leading kept after mid-bit change", lead_n, 4);
        measure(0, -1, 1'b0, busy, lead_n, l_idx, l_n, s_idx, s_n);
        chk("R8", "new field used at next start", busy, 3);

        // R9: enable low blocks a start
        @(negedge clk);
        enable = 1'b0;
        bit_req = 1'b1;
        busy = 0; l_n = 0; s_n = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (!idle) busy++;
            if (launch) l_n++;
            if (sample) s_n++;
        end
        bit_req = 1'b0;
        enable = 1'b1;
        chk("R9", "busy cycles while disabled", busy, 0);
        chk("R9", "launch while disabled", l_n, 0);
        chk("R9", "sample while disabled", s_n, 0);

        // R9: enable dropped mid-bit lets the bit finish
        @(negedge clk);
        field = 5'd5;
        measure(0, -1, 1'b1, busy, lead_n, l_idx, l_n, s_idx, s_n);
        chk("R9", "full period after enable drop", busy, 5);

        // R10: request held across the end of the trailing phase
        @(negedge clk);
        field = 5'd3; cpha = 1'b1;
        measure(3, -1, 1'b0, busy, lead_n, l_idx, l_n, s_idx, s_n);
        chk("R10", "two chained bits busy cycles", busy, 6);
        chk("R10", "chained leading cycles", lead_n, 4);
        chk("R10", "chained launch count", l_n, 2);
        chk("R10", "chained sample count", s_n, 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule